// File: doc/BRIEF.md
# Receive Buffer with Threshold-Driven Flow Control

This block sits between a serial receiver and a host. The receiver pushes bytes into a 32-entry queue, and the host pulls them out in arrival order. The block watches the queue occupancy and drives an active-low request-to-send line toward the remote transmitter. When that line is low, the far end is allowed to send.

The host selects one of five receive thresholds. A data-ready interrupt is raised whenever the occupancy is at or above the selected threshold. When automatic flow control is on, the request line goes high (stop) once the occupancy climbs to the next threshold above the selected one. It returns low (go) only after the host drains the queue to the next threshold below. Between those two points the line keeps its state. Bytes that arrive after the stop signal are still stored until the queue is completely full. A push into a full queue is lost and recorded in a sticky overrun flag.

When automatic flow control is off, the request line simply mirrors a host-supplied level.

Top module: `rxq_flow_ctl`

## Requirements
- R1: Bytes are read out in the order they were accepted. The byte selected by an accepted read appears on `rd_byte` one clock after the read strobe and holds until the next accepted read. `fill_level` gives the number of stored bytes after each clock.
- R2: A push while `fill_level` is 32 is discarded, and `overrun` goes to 1 on the next clock. `overrun` stays 1 until a clock where `ovr_clr` is 1 and no push is discarded. A discard in the same clock as `ovr_clr` leaves `overrun` at 1.
- R3: A read strobe while the queue is empty changes neither `fill_level` nor `rd_byte`.
- R4: `trig_sel` encodes the threshold: 0 selects 1, 1 selects 8, 2 selects 16, 3 selects 24, and 4 through 7 select 28. `rx_ready_irq` is 1 exactly when `fill_level` is at or above the selected threshold.
- R5: With `auto_rts_en` at 1, `rts_n` becomes 1 in the clock where `fill_level` reaches the stop level. The stop level is 8, 16, 24, 28 or 32 for thresholds 1, 8, 16, 24 and 28 respectively.
- R6: With `auto_rts_en` at 1, `rts_n` returns to 0 in the clock where `fill_level` falls to or below the resume level. The resume level is 0, 1, 8, 16 or 24 for thresholds 1, 8, 16, 24 and 28 respectively. Strictly between the resume and stop levels, `rts_n` keeps its previous value.
- R7: While `rts_n` is 1, pushes are still accepted until `fill_level` reaches 32.
- R8: With `auto_rts_en` at 0, `rts_n` equals `man_rts_n` in the same cycle.
- R9: After reset, `fill_level` is 0, `overrun` is 0 and `rd_byte` is 0. With `auto_rts_en` at 1, `rts_n` is 0.
- R10: When a push and a read arrive in the same clock, both are accepted, except in two cases. On a full queue, only the read is accepted and the push counts as a discard. On an empty queue, only the push is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push strobe from the receiver |
| wr_byte | input | 8 | Byte to push |
| rd_en | input | 1 | Read strobe from the host |
| rd_byte | output | 8 | Last byte read out |
| trig_sel | input | 3 | Receive threshold select |
| auto_rts_en | input | 1 | Automatic flow control enable |
| man_rts_n | input | 1 | Host level used for `rts_n` when automatic control is off |
| ovr_clr | input | 1 | Clears the overrun flag |
| rts_n | output | 1 | Active-low request-to-send |
| rx_ready_irq | output | 1 | Occupancy at or above threshold |
| overrun | output | 1 | Sticky lost-byte flag |
| fill_level | output | 6 | Number of stored bytes |

## Verification
The hardest state to reach is the hold band. There the occupancy lies strictly between the resume and stop levels, and `rts_n` depends on whether the queue last came from above or from below. The stimulus fills the queue past the stop level and then drains it to the resume level, for each threshold code. On every clock `rts_n` is compared with a model that tracks the stop state on its own. Additional fill and drain sequences drive the queue to exactly 32 and to exactly 0 with both strobes active, so the discard and empty-read rules are exercised at the boundaries.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned RXQ_DEPTH = 32;
    localparam int unsigned RXQ_WIDTH = 8;
    localparam int unsigned RXQ_CW    = $clog2(RXQ_DEPTH) + 1;

    typedef logic [RXQ_CW-1:0] rxq_cnt_t;

    // queue operation selected in a cycle
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_SWAP = 2'b11
    } rxq_op_e;

    // threshold triple: selected level, stop level, resume level
    typedef struct packed {
        rxq_cnt_t lvl;
        rxq_cnt_t hi;
        rxq_cnt_t lo;
    } rxq_thr_t;

    function automatic rxq_thr_t rxq_thresholds(input logic [2:0] sel);
        rxq_thr_t t;
        case (sel)
            3'd0:    begin t.lvl = rxq_cnt_t'(1);  t.hi = rxq_cnt_t'(8);  t.lo = rxq_cnt_t'(0);  end
            3'd1:    begin t.lvl = rxq_cnt_t'(8);  t.hi = rxq_cnt_t'(16); t.lo = rxq_cnt_t'(1);  end
            3'd2:    begin t.lvl = rxq_cnt_t'(16); t.hi = rxq_cnt_t'(24); t.lo = rxq_cnt_t'(8);  end
            3'd3:    begin t.lvl = rxq_cnt_t'(24); t.hi = rxq_cnt_t'(28); t.lo = rxq_cnt_t'(16); end
            default: begin t.lvl = rxq_cnt_t'(28); t.hi = rxq_cnt_t'(RXQ_DEPTH); t.lo = rxq_cnt_t'(24); end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] pop_data,
    output rxq_cnt_t         cnt_q,
    output rxq_cnt_t         cnt_nxt,
    output logic             push_lost
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam rxq_cnt_t    FULL_CNT = rxq_cnt_t'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic             push_ok, pop_ok;
    rxq_op_e          op;

    assign push_ok   = push_req && (cnt_q != FULL_CNT);
    assign pop_ok    = pop_req && (cnt_q != '0);
    assign push_lost = push_req && !push_ok;
    assign op        = rxq_op_e'({push_ok, pop_ok});

    always_comb begin
        case (op)
            OP_PUSH: cnt_nxt = cnt_q + 1'b1;
            OP_POP:  cnt_nxt = cnt_q - 1'b1;
            default: cnt_nxt = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q     <= '0;
            rp_q     <= '0;
            cnt_q    <= '0;
            pop_data <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (pop_ok) begin
                pop_data <= mem[rp_q];
                rp_q     <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            end
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

    p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL_CNT && push_req && !pop_req) |=> (cnt_q == FULL_CNT));

    p_empty_read_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && pop_req) |=> $stable(pop_data));

    p_step_r10: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && cnt_q != '0 && cnt_q != FULL_CNT) |=> $stable(cnt_q));

endmodule

// File: rtl/rxq_rts_hyst.sv
module rxq_rts_hyst
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    input  rxq_cnt_t   cnt_q,
    input  rxq_cnt_t   cnt_nxt,
    input  logic       auto_en,
    input  logic       man_n,
    output logic       rts_n,
    output logic       ready_irq
);
    rxq_thr_t thr;
    logic     stop_q;

    assign thr = rxq_thresholds(sel);

    // stop state follows the next count so it lines up with cnt_q
    always_ff @(posedge clk) begin
        if (rst)                        stop_q <= 1'b0;
        else if (cnt_nxt >= thr.hi)     stop_q <= 1'b1;
        else if (cnt_nxt <= thr.lo)     stop_q <= 1'b0;
    end

    assign rts_n     = auto_en ? stop_q : man_n;
    assign ready_irq = (cnt_q >= thr.lvl);

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        ($stable(sel) && cnt_q >= thr.hi) |-> stop_q);

    p_resume_r6: assert property (@(posedge clk) disable iff (rst)
        ($stable(sel) && cnt_q <= thr.lo) |-> !stop_q);

endmodule

// File: rtl/rxq_flow_ctl.sv
module rxq_flow_ctl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = RXQ_DEPTH,
    parameter int unsigned WIDTH = RXQ_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_byte,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_byte,
    input  logic [2:0]       trig_sel,
    input  logic             auto_rts_en,
    input  logic             man_rts_n,
    input  logic             ovr_clr,
    output logic             rts_n,
    output logic             rx_ready_irq,
    output logic             overrun,
    output logic [RXQ_CW-1:0] fill_level
);
    rxq_cnt_t cnt_q, cnt_nxt;
    logic     lost;

    rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push_req (wr_en),
        .push_data(wr_byte),
        .pop_req  (rd_en),
        .pop_data (rd_byte),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .push_lost(lost)
    );

    rxq_rts_hyst u_hyst (
        .clk      (clk),
        .rst      (rst),
        .sel      (trig_sel),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .auto_en  (auto_rts_en),
        .man_n    (man_rts_n),
        .rts_n    (rts_n),
        .ready_irq(rx_ready_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)          overrun <= 1'b0;
        else if (lost)    overrun <= 1'b1;
        else if (ovr_clr) overrun <= 1'b0;
    end

    assign fill_level = cnt_q;

    p_ovr_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    p_ovr_set_r2: assert property (@(posedge clk) disable iff (rst)
        lost |=> overrun);

endmodule

// File: tb/rxq_flow_ctl_bench.sv
module rxq_flow_ctl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
    logic [7:0] wr_byte = '0;
    logic [2:0] trig_sel = 3'd2;
    logic       auto_rts_en = 1'b1, man_rts_n = 1'b1;
    logic [7:0] rd_byte;
    logic       rts_n, rx_ready_irq, overrun;
    logic [5:0] fill_level;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string phase = "R9 reset";

    // reference model state
    byte unsigned q[$];
    int  e_rd = 0;
    bit  e_ovr = 0, e_stop = 0;

    always #5 clk = ~clk;

    rxq_flow_ctl u_rxq_flow_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .rd_en(rd_en),
        .rd_byte(rd_byte), .trig_sel(trig_sel), .auto_rts_en(auto_rts_en),
        .man_rts_n(man_rts_n), .ovr_clr(ovr_clr), .rts_n(rts_n),
        .rx_ready_irq(rx_ready_irq), .overrun(overrun), .fill_level(fill_level)
    );

    function automatic int lvl_of(int s);
        if (s == 0) return 1;
        if (s == 1) return 8;
        if (s == 2) return 16;
        if (s == 3) return 24;
        return 28;
    endfunction
    function automatic int hi_of(int s);
        if (s == 0) return 8;
        if (s == 1) return 16;
        if (s == 2) return 24;
        if (s == 3) return 28;
        return 32;
    endfunction
    function automatic int lo_of(int s);
        if (s == 0) return 0;
        if (s == 1) return 1;
        if (s == 2) return 8;
        if (s == 3) return 16;
        return 24;
    endfunction

    task automatic model_step();
        bit can_rd, can_wr, dropped;
        if (rst) begin
            q.delete(); e_rd = 0; e_ovr = 0; e_stop = 0;
            return;
        end
        can_rd  = rd_en && q.size() > 0;
        can_wr  = wr_en && q.size() < 32;
        dropped = wr_en && !can_wr;
        if (can_rd) e_rd = q.pop_front();
        if (can_wr) q.push_back(wr_byte);
        if (dropped) e_ovr = 1;
        else if (ovr_clr) e_ovr = 0;
        if (q.size() >= hi_of(trig_sel)) e_stop = 1;
        else if (q.size() <= lo_of(trig_sel)) e_stop = 0;
    endtask

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 fill", fill_level, q.size());
        chk("R1/R3 rd_byte", rd_byte, e_rd);
        chk("R4 irq", rx_ready_irq, (q.size() >= lvl_of(trig_sel)) ? 1 : 0);
        chk("R5/R6/R8 rts_n", rts_n, auto_rts_en ? e_stop : man_rts_n);
        chk("R2 overrun", overrun, e_ovr);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(bit w, bit r);
        wr_en = w; rd_en = r; wr_byte = 8'($urandom); cyc();
        wr_en = 0; rd_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        phase = "R9 after reset";
        cyc();
        chk("R9 rts_n low", rts_n, 0);

        phase = "R5 R7 fill with threshold 16";
        for (int i = 0; i < 32; i++) drive(1, 0);
        chk("R7 full reached", fill_level, 32);
        chk("R5 stopped", rts_n, 1);

        phase = "R2 push on full";
        drive(1, 0);
        drive(1, 0);
        chk("R2 overrun set", overrun, 1);
        ovr_clr = 1; wr_en = 1; cyc(); wr_en = 0;
        chk("R2 set wins over clear", overrun, 1);
        cyc(); ovr_clr = 0;
        chk("R2 cleared", overrun, 0);

        phase = "R10 both on full";
        drive(1, 1);
        chk("R10 full swap", fill_level, 31);

        phase = "R6 drain through hold band";
        for (int i = 0; i < 31; i++) drive(0, 1);
        chk("R6 resumed", rts_n, 0);

        phase = "R3 read empty";
        drive(0, 1);
        drive(0, 1);
        chk("R3 fill stays 0", fill_level, 0);

        phase = "R10 both on empty";
        drive(1, 1);
        chk("R10 empty push", fill_level, 1);
        drive(0, 1);

        for (int s = 0; s < 8; s++) begin
            trig_sel = 3'(s);
            phase = $sformatf("R4 R5 R6 sweep sel %0d", s);
            cyc();
            for (int i = 0; i < 33; i++) drive(1, 0);
            ovr_clr = 1; cyc(); ovr_clr = 0;
            for (int i = 0; i < 33; i++) drive(0, 1);
        end

        phase = "R8 manual level";
        auto_rts_en = 0;
        for (int i = 0; i < 20; i++) begin
            man_rts_n = i[0];
            drive(1, 0);
        end
        chk("R8 follows host", rts_n, man_rts_n);
        auto_rts_en = 1;

        phase = "R1 random mix";
        for (int i = 0; i < 3000; i++) begin
            trig_sel    = (i % 400 == 0) ? 3'($urandom_range(0, 7)) : trig_sel;
            auto_rts_en = (i % 500 < 450);
            man_rts_n   = 1'($urandom);
            ovr_clr     = ($urandom_range(0, 15) == 0);
            drive(($urandom_range(0, 99) < ((i / 300) % 2 ? 35 : 65)),
                  ($urandom_range(0, 99) < ((i / 300) % 2 ? 65 : 35)));
            ovr_clr = 0;
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule